// File: doc/BRIEF.md
# Instruction-Alignment Control Slice

This block keeps the part of a machine-mode control-register file that decides how instructions must be aligned. It stores the compressed-instruction enable bit of the ISA description register. From that bit it derives the current instruction alignment: 16 bits when the bit is set, 32 bits when it is clear. It also stores one exception-PC register for each of three privilege levels (machine, supervisor, user). Reads of these registers pass through a mask that depends on the alignment.

Software writes arrive as single-cycle requests. Each request carries a register select, write data and the PC of the writing instruction. Read data comes back combinationally for the selected register. A return instruction takes its exception PC from a separate read port, which uses the same mask. Jump and branch targets are checked against the current alignment. A misaligned target raises a one-cycle trap request that carries the PC of the jump itself.

Top module: `ialign_csr_unit`

## Requirements
- R1: After a synchronous reset, the compressed bit reads as 1, every exception-PC register reads as zero, and `trap_req` is 0.
- R2: The ISA register reads as the constant `ISA_BASE`, with bit 2 replaced by the compressed bit. A write takes effect at the next clock edge. A write that sets bit 2 is always accepted. A write that clears bit 2 is accepted when bit 1 of `cur_pc` is 0.
- R3: A write that would clear bit 2 while bit 1 of `cur_pc` is 1 is dropped entirely, and the compressed bit stays 1.
- R4: Every ISA register bit other than bit 2 is read-only, and writes leave those bits unchanged.
- R5: An exception-PC write stores write-data bits [XLEN-1:1]. Bit 0 always reads as 0. The selects are 1 for machine, 2 for supervisor and 3 for user.
- R6: While the compressed bit is 0, exception-PC reads return bits [1:0] as zero, but a write still stores bit 1.
- R7: A bit 1 that was stored or hidden while alignment was 32 becomes visible again once the compressed bit returns to 1.
- R8: `ret_pc` for level `ret_lvl` (0 machine, 1 supervisor, 2 user) passes through the same mask, so it is 32-bit aligned while the compressed bit is 0.
- R9: A jump with target bit 1 set while the compressed bit is 0 raises `trap_req` in the cycle after the request, with `trap_pc` equal to the jump's `cur_pc`. Target bit 0 is ignored, and no trap is raised while the compressed bit is 1.
- R10: ISA writes, exception-PC writes and returns never raise `trap_req`. Only `jmp_valid` can raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr_en | input | 1 | Write request for one cycle |
| csr_sel | input | 2 | Register select: 0 ISA, 1 machine EPC, 2 supervisor EPC, 3 user EPC |
| csr_wdata | input | XLEN | Write data |
| cur_pc | input | XLEN | PC of the instruction that is writing or jumping |
| csr_rdata | output | XLEN | Masked read data for `csr_sel` (combinational) |
| ret_lvl | input | 2 | Level whose exception PC a return uses |
| ret_pc | output | XLEN | Masked exception PC for `ret_lvl` |
| jmp_valid | input | 1 | A jump or branch presents its target |
| jmp_target | input | XLEN | Jump or branch target address |
| comp_en | output | 1 | Current compressed bit (1 means 16-bit alignment) |
| trap_req | output | 1 | Misaligned-target trap request |
| trap_pc | output | XLEN | PC of the faulting jump |

## Verification
Register writes are due one clock edge after the request. The masked read ports are combinational, so they show a new mode or value right after that same edge. The trap outputs are registered and appear on the edge that samples `jmp_valid`. The bench therefore drives each request on a falling edge and waits through exactly one rising edge. It samples every output at the following falling edge. Idle steps read registers back without writing, which shows that hidden bits persist across mode changes.

// File: rtl/ialign_pkg.sv
package ialign_pkg;

    // register select encoding at the CSR port
    typedef enum logic [1:0] {
        SEL_ISA   = 2'd0,
        SEL_EPC_M = 2'd1,
        SEL_EPC_S = 2'd2,
        SEL_EPC_U = 2'd3
    } csr_sel_e;

    localparam int COMP_BIT = 2;
    localparam int NUM_LVL  = 3;
    localparam int LVL_W    = 2;

    // mask for the two low address bits under the current mode
    function automatic logic [1:0] low_mask(input logic comp);
        return comp ? 2'b10 : 2'b00;
    endfunction

    // a target is misaligned when bit 1 is set under 32-bit alignment
    function automatic logic tgt_bad(input logic bit1, input logic comp);
        return bit1 & ~comp;
    endfunction

endpackage

// File: rtl/isa_ctrl.sv
module isa_ctrl
    import ialign_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_isa,
    input  logic wdata_comp,
    input  logic pc_bit1,
    output logic comp_o
);
    logic comp_q;
    logic drop_w;

    // clearing the bit from an unaligned PC is refused
    assign drop_w = comp_q & ~wdata_comp & pc_bit1;

    always_ff @(posedge clk) begin
        if (rst)
            comp_q <= 1'b1;
        else if (wr_isa && !drop_w)
            comp_q <= wdata_comp;
    end

    assign comp_o = comp_q;

    AST_CLEAR_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (wr_isa && !wdata_comp && pc_bit1 && comp_o) |=> comp_o); // R3
    AST_CLEAR_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (wr_isa && !wdata_comp && !pc_bit1) |=> !comp_o); // R2
    AST_SET_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (wr_isa && wdata_comp) |=> comp_o); // R2
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_isa |=> $stable(comp_o)); // R2

endmodule

// File: rtl/epc_bank.sv
module epc_bank
    import ialign_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [LVL_W-1:0] wr_lvl,
    input  logic [XLEN-1:0]  wdata,
    input  logic             comp,
    input  logic [LVL_W-1:0] rd_lvl,
    output logic [XLEN-1:0]  rd_data,
    input  logic [LVL_W-1:0] ret_lvl,
    output logic [XLEN-1:0]  ret_data
);
    logic [XLEN-1:1] epc_q [NUM_LVL];

    // bit 1 is stored in every mode; only the read path hides it
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_LVL; i++) begin
            if (rst)
                epc_q[i] <= '0;
            else if (wr_en && wr_lvl == LVL_W'(i))
                epc_q[i] <= wdata[XLEN-1:1];
        end
    end

    function automatic logic [XLEN-1:0] view(input logic [LVL_W-1:0] lvl,
                                             input logic c);
        logic [XLEN-1:0] v;
        v = '0;
        for (int i = 0; i < NUM_LVL; i++)
            if (lvl == LVL_W'(i))
                v = {epc_q[i][XLEN-1:2], epc_q[i][1] & low_mask(c)[1], 1'b0};
        return v;
    endfunction

    assign rd_data  = view(rd_lvl, comp);
    assign ret_data = view(ret_lvl, comp);

    generate
        for (genvar g = 0; g < NUM_LVL; g++) begin : g_chk
            AST_EPC_STORE: assert property (@(posedge clk) disable iff (rst)
                (wr_en && wr_lvl == LVL_W'(g))
                |=> epc_q[g] == $past(wdata[XLEN-1:1])); // R5
            AST_EPC_KEEP: assert property (@(posedge clk) disable iff (rst)
                !wr_en |=> $stable(epc_q[g])); // R7
        end
    endgenerate

    AST_RET_ALIGN: assert property (@(posedge clk) disable iff (rst)
        !comp |-> ret_data[1:0] == 2'b00); // R8
    AST_RD_ALIGN: assert property (@(posedge clk) disable iff (rst)
        !comp |-> rd_data[1:0] == 2'b00); // R6

endmodule

// File: rtl/tgt_check.sv
module tgt_check
    import ialign_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            jmp_valid,
    input  logic [XLEN-1:0] target,
    input  logic [XLEN-1:0] pc,
    input  logic            comp,
    output logic            trap_o,
    output logic [XLEN-1:0] trap_pc_o
);
    logic            trap_q;
    logic [XLEN-1:0] tpc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_q <= 1'b0;
            tpc_q  <= '0;
        end else begin
            trap_q <= jmp_valid & tgt_bad(target[1], comp);
            if (jmp_valid)
                tpc_q <= pc;
        end
    end

    assign trap_o    = trap_q;
    assign trap_pc_o = tpc_q;

    AST_TRAP_RAISE: assert property (@(posedge clk) disable iff (rst)
        (jmp_valid && target[1] && !comp) |=> (trap_o && trap_pc_o == $past(pc))); // R9
    AST_TRAP_ONLY_JUMP: assert property (@(posedge clk) disable iff (rst)
        !jmp_valid |=> !trap_o); // R10
    AST_TRAP_COMP_SAFE: assert property (@(posedge clk) disable iff (rst)
        (jmp_valid && comp) |=> !trap_o); // R9

endmodule

// File: rtl/ialign_csr_unit.sv
module ialign_csr_unit
    import ialign_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter logic [31:0] ISA_BASE = 32'h4000_0100
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            csr_wr_en,
    input  logic [1:0]      csr_sel,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic [XLEN-1:0] cur_pc,
    output logic [XLEN-1:0] csr_rdata,
    input  logic [1:0]      ret_lvl,
    output logic [XLEN-1:0] ret_pc,
    input  logic            jmp_valid,
    input  logic [XLEN-1:0] jmp_target,
    output logic            comp_en,
    output logic            trap_req,
    output logic [XLEN-1:0] trap_pc
);
    localparam logic [XLEN-1:0] ISA_FIXED =
        XLEN'(ISA_BASE) & ~(XLEN'(1) << COMP_BIT);

    csr_sel_e         sel_w;
    logic             wr_isa_w;
    logic             wr_epc_w;
    logic [LVL_W-1:0] epc_lvl_w;
    logic [XLEN-1:0]  epc_rd_w;
    logic             comp_w;

    assign sel_w     = csr_sel_e'(csr_sel);
    assign wr_isa_w  = csr_wr_en && sel_w == SEL_ISA;
    assign wr_epc_w  = csr_wr_en && sel_w != SEL_ISA;
    assign epc_lvl_w = csr_sel - 2'd1;

    isa_ctrl u_isa (
        .clk        (clk),
        .rst        (rst),
        .wr_isa     (wr_isa_w),
        .wdata_comp (csr_wdata[COMP_BIT]),
        .pc_bit1    (cur_pc[1]),
        .comp_o     (comp_w)
    );

    epc_bank #(.XLEN(XLEN)) u_epc (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_epc_w),
        .wr_lvl   (epc_lvl_w),
        .wdata    (csr_wdata),
        .comp     (comp_w),
        .rd_lvl   (epc_lvl_w),
        .rd_data  (epc_rd_w),
        .ret_lvl  (ret_lvl),
        .ret_data (ret_pc)
    );

    tgt_check #(.XLEN(XLEN)) u_tgt (
        .clk       (clk),
        .rst       (rst),
        .jmp_valid (jmp_valid),
        .target    (jmp_target),
        .pc        (cur_pc),
        .comp      (comp_w),
        .trap_o    (trap_req),
        .trap_pc_o (trap_pc)
    );

    always_comb begin
        if (sel_w == SEL_ISA)
            csr_rdata = ISA_FIXED | (XLEN'(comp_w) << COMP_BIT);
        else
            csr_rdata = epc_rd_w;
    end

    assign comp_en = comp_w;

    AST_ISA_FIXED: assert property (@(posedge clk) disable iff (rst)
        (sel_w == SEL_ISA) |-> (csr_rdata & ~(XLEN'(1) << COMP_BIT)) == ISA_FIXED); // R4
    AST_EPC_WR_NO_MODE: assert property (@(posedge clk) disable iff (rst)
        (wr_epc_w && !wr_isa_w) |=> $stable(comp_en)); // R5

endmodule

// File: tb/ialign_csr_unit_tb.sv
module ialign_csr_unit_tb_top;

    typedef struct packed {
        logic [1:0]  kind;   // 0 write, 1 jump, 2 idle read
        logic [1:0]  sel;
        logic [31:0] data;   // write data or jump target
        logic [31:0] pc;
        logic        e_comp;
        logic [31:0] e_rd;   // expected csr_rdata for sel after the edge
        logic        e_trap;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd1, 32'h0000_1006, 32'h0000_0100, 1'b1, 32'h0000_1006, 1'b0}, // R5
        '{2'd0, 2'd2, 32'h0000_2003, 32'h0000_0104, 1'b1, 32'h0000_2002, 1'b0}, // R5 R10
        '{2'd0, 2'd0, 32'h0000_0000, 32'h0000_0102, 1'b1, 32'h4000_0104, 1'b0}, // R3
        '{2'd1, 2'd0, 32'h0000_0302, 32'h0000_0200, 1'b1, 32'h4000_0104, 1'b0}, // R9
        '{2'd0, 2'd0, 32'hFFFF_FFFB, 32'h0000_0104, 1'b0, 32'h4000_0100, 1'b0}, // R2 R4
        '{2'd2, 2'd1, 32'h0000_0000, 32'h0000_0000, 1'b0, 32'h0000_1004, 1'b0}, // R6
        '{2'd0, 2'd3, 32'h0000_3006, 32'h0000_0108, 1'b0, 32'h0000_3004, 1'b0}, // R6
        '{2'd1, 2'd0, 32'h0000_0502, 32'h0000_0400, 1'b0, 32'h4000_0100, 1'b1}, // R9
        '{2'd1, 2'd0, 32'h0000_0501, 32'h0000_0404, 1'b0, 32'h4000_0100, 1'b0}, // R9
        '{2'd0, 2'd0, 32'h0000_0004, 32'h0000_010A, 1'b1, 32'h4000_0104, 1'b0}, // R2
        '{2'd2, 2'd3, 32'h0000_0000, 32'h0000_0000, 1'b1, 32'h0000_3006, 1'b0}, // R7
        '{2'd2, 2'd2, 32'h0000_0000, 32'h0000_0000, 1'b1, 32'h0000_2002, 1'b0}  // R7
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        csr_wr_en;
    logic [1:0]  csr_sel;
    logic [31:0] csr_wdata;
    logic [31:0] cur_pc;
    logic [31:0] csr_rdata;
    logic [1:0]  ret_lvl;
    logic [31:0] ret_pc;
    logic        jmp_valid;
    logic [31:0] jmp_target;
    logic        comp_en;
    logic        trap_req;
    logic [31:0] trap_pc;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    ialign_csr_unit dut_i (
        .clk(clk), .rst(rst), .csr_wr_en(csr_wr_en), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .cur_pc(cur_pc), .csr_rdata(csr_rdata),
        .ret_lvl(ret_lvl), .ret_pc(ret_pc), .jmp_valid(jmp_valid),
        .jmp_target(jmp_target), .comp_en(comp_en), .trap_req(trap_req),
        .trap_pc(trap_pc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        csr_wr_en = 1'b0; jmp_valid = 1'b0;
        csr_wdata = '0; jmp_target = '0; cur_pc = '0;
    endtask

    // drive on the falling edge, pass one rising edge, sample at next falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        idle_inputs();
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; csr_sel = '0; ret_lvl = '0;
        idle_inputs();
        do_reset();

        // R1 reset state
        check("R1 comp", {31'd0, comp_en}, 32'd1);
        check("R1 trap", {31'd0, trap_req}, 32'd0);
        for (int s = 1; s < 4; s++) begin
            csr_sel = 2'(s); #1;
            check("R1 epc", csr_rdata, 32'd0);
        end

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            csr_sel = VECS[i].sel;
            cur_pc  = VECS[i].pc;
            case (VECS[i].kind)
                2'd0: begin csr_wr_en = 1'b1; csr_wdata = VECS[i].data; end
                2'd1: begin jmp_valid = 1'b1; jmp_target = VECS[i].data; end
                default: ;
            endcase
            step();
            check("R2/R3 comp", {31'd0, comp_en}, {31'd0, VECS[i].e_comp});
            check("R4-R7 read", csr_rdata, VECS[i].e_rd);
            check("R9/R10 trap", {31'd0, trap_req}, {31'd0, VECS[i].e_trap});
            if (VECS[i].e_trap)
                check("R9 trap_pc", trap_pc, VECS[i].pc);
        end

        // R8 return path masking, comp currently 1
        ret_lvl = 2'd2; #1;
        check("R8 ret comp1", ret_pc, 32'h0000_3006);
        @(negedge clk);
        csr_sel = 2'd0; csr_wr_en = 1'b1; csr_wdata = 32'h0; cur_pc = 32'h0000_0200;
        step();
        check("R2 clear aligned", {31'd0, comp_en}, 32'd0);
        check("R8 ret comp0", ret_pc, 32'h0000_3004);
        ret_lvl = 2'd0; #1;
        check("R8 ret machine", ret_pc, 32'h0000_1004);
        check("R10 no trap", {31'd0, trap_req}, 32'd0);

        // R6 bit 1 stored while hidden, then R7 reappears
        @(negedge clk);
        csr_sel = 2'd1; csr_wr_en = 1'b1; csr_wdata = 32'h0000_7772; cur_pc = 32'h0000_0204;
        step();
        check("R6 hidden", csr_rdata, 32'h0000_7770);
        @(negedge clk);
        csr_sel = 2'd0; csr_wr_en = 1'b1; csr_wdata = 32'h0000_0004; cur_pc = 32'h0000_0208;
        step();
        csr_sel = 2'd1; #1;
        check("R7 reappear", csr_rdata, 32'h0000_7772);

        // R1 reset in mid-run
        do_reset();
        csr_sel = 2'd1; #1;
        check("R1 epc after reset", csr_rdata, 32'd0);
        check("R1 comp after reset", {31'd0, comp_en}, 32'd1);

        finish_run();
    end

endmodule